// File: doc/BRIEF.md
# NAND Ready/Busy Interrupt Unit

This unit watches a small group of NAND flash ready/busy lines and turns their activity, together with event pulses from the rest of the controller, into one level-sensitive interrupt. Each line is held low by the flash device while it is busy and goes high when the device is ready. Every line passes through a synchroniser, and its live level can be read at any time. One line, picked by a field in the control register, can raise a busy-to-ready event. The command engine and the DMA engine each report completion with a single-cycle pulse.

Software reads and writes three word registers through a simple single-cycle register port. The status register holds the three sticky event flags and the live line levels. The enable register decides which flags reach the interrupt pin. The control register holds the line select and a self-clearing soft-reset bit. A flag is cleared by writing a one to its bit.

Top module: `nrb_irq_top`

## Requirements
- R1: After the synchronous reset `rst`, every event flag and every enable bit is 0, `irq` is low, the control register reads 0, and the live level bits read 1 while all lines are held high.
- R2: Status bits 8 upward (bit 8+i for line i) show the synchronised level of line i, 1 meaning ready. A change on `rb_line` appears in the read value after exactly two rising clock edges.
- R3: Status bit 0 (busy-to-ready flag) is set by a low-to-high transition of the selected line. It becomes visible three edges after the input rises, and a transition on any unselected line leaves it at 0.
- R4: The line select is the control register field starting at bit 3 (2 bits wide for four lines). It is written and read back there, and it is kept across a soft reset.
- R5: A one-cycle pulse on `ev_cmd_done` sets status bit 1, and a pulse on `ev_dma_done` sets status bit 2. Each is visible after the next edge.
- R6: A write to the status register (address 0) clears every flag whose data bit 0..2 is 1 and leaves every flag whose data bit is 0 unchanged.
- R7: When an event that sets a flag and a write-one-to-clear of the same flag fall in the same cycle, the flag ends set.
- R8: Flags are set whatever the enable register (address 1, bits 0..2 in the same positions as the flags) holds. `irq` is high exactly when some flag and its enable bit are both 1.
- R9: Writing 1 to control bit 1 (address 2) starts a soft reset. Bit 1 reads 1 for one cycle, then the next edge clears all flags and enables and the bit reads 0 again.
- R10: A high-to-low transition (ready to busy) of the selected line does not set the busy-to-ready flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rb_line | input | 4 | Asynchronous ready/busy lines, low while busy |
| ev_cmd_done | input | 1 | One-cycle command-complete pulse |
| ev_dma_done | input | 1 | One-cycle DMA-complete pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register word address: 0 status, 1 enable, 2 control |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| irq | output | 1 | Interrupt, high while an enabled flag is set |

## Verification
The assertions assume that the event inputs are single-cycle pulses and that register writes are whole-word writes on a settled address. They also assume that the ready/busy lines hold each level for at least three clock cycles, so that the synchroniser sees every edge. The directed stimulus changes the lines and pulses only just after a clock edge, and it keeps every line level for four or more cycles. Before it looks for a flag, it waits out the two-flop latency plus the edge register.

// File: rtl/nrb_pkg.sv
package nrb_pkg;
    localparam int DW       = 32;
    localparam int LIVE_LSB = 8;
    localparam int SEL_LSB  = 3;
    localparam int SRST_BIT = 1;
    localparam int NEVT     = 3;

    typedef enum logic [1:0] {
        RA_STATUS = 2'd0,
        RA_IRQEN  = 2'd1,
        RA_CTRL   = 2'd2,
        RA_NONE   = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic dma;
        logic cmd;
        logic b2r;
    } evt_t;

    function automatic evt_t bits_to_evt(input logic [NEVT-1:0] v);
        evt_t e;
        e.b2r = v[0];
        e.cmd = v[1];
        e.dma = v[2];
        return e;
    endfunction

    function automatic logic [NEVT-1:0] evt_to_bits(input evt_t e);
        return {e.dma, e.cmd, e.b2r};
    endfunction
endpackage

// File: rtl/nrb_line_sync.sv
module nrb_line_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] rb_line,
    output logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_line
        logic [2:0] sh;
        always_ff @(posedge clk) begin
            if (rst) sh <= 3'b111;
            else     sh <= {sh[1:0], rb_line[g]};
        end
        assign lvl[g]  = sh[1];
        assign rise[g] = sh[1] & ~sh[2];
    end
endmodule

// File: rtl/nrb_rise_pick.sv
module nrb_rise_pick #(
    parameter int N    = 4,
    parameter int SELW = 2
) (
    input  logic [N-1:0]    rise,
    input  logic [SELW-1:0] sel,
    output logic            rise_sel
);
    always_comb begin
        rise_sel = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (int'(sel) == i) rise_sel = rise[i];
        end
    end
endmodule

// File: rtl/nrb_evt_regs.sv
module nrb_evt_regs
    import nrb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic srst,
    input  evt_t set,
    input  evt_t clr,
    input  logic en_wr,
    input  evt_t en_wdata,
    output evt_t flags,
    output evt_t en
);
    logic [NEVT-1:0] flag_q, en_q;

    always_ff @(posedge clk) begin
        if (rst || srst) begin
            flag_q <= '0;
            en_q   <= '0;
        end else begin
            flag_q <= (flag_q & ~evt_to_bits(clr)) | evt_to_bits(set);
            if (en_wr) en_q <= evt_to_bits(en_wdata);
        end
    end

    assign flags = bits_to_evt(flag_q);
    assign en    = bits_to_evt(en_q);
endmodule

// File: rtl/nrb_irq_top.sv
module nrb_irq_top
    import nrb_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  rb_line,
    input  logic          ev_cmd_done,
    input  logic          ev_dma_done,
    input  logic          bus_wr,
    input  logic [1:0]    bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);
    localparam int SELW = (N > 1) ? $clog2(N) : 1;

    reg_addr_e       addr;
    logic [N-1:0]    lvl, rise;
    logic            rise_sel;
    logic [SELW-1:0] sel_q;
    logic            srst_q;
    evt_t            set_v, clr_v, flags, en;
    logic            wr_status, wr_en, wr_ctrl;
    logic            unused_wdata;

    assign addr      = reg_addr_e'(bus_addr);
    assign wr_status = bus_wr && (addr == RA_STATUS);
    assign wr_en     = bus_wr && (addr == RA_IRQEN);
    assign wr_ctrl   = bus_wr && (addr == RA_CTRL);
    assign unused_wdata = ^bus_wdata;

    nrb_line_sync #(.N(N)) u_sync (
        .clk(clk), .rst(rst), .rb_line(rb_line), .lvl(lvl), .rise(rise)
    );

    nrb_rise_pick #(.N(N), .SELW(SELW)) u_pick (
        .rise(rise), .sel(sel_q), .rise_sel(rise_sel)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            srst_q <= 1'b0;
        end else begin
            if (srst_q)
                srst_q <= 1'b0;
            else if (wr_ctrl && bus_wdata[SRST_BIT])
                srst_q <= 1'b1;
            if (wr_ctrl)
                sel_q <= bus_wdata[SEL_LSB +: SELW];
        end
    end

    always_comb begin
        set_v     = '0;
        set_v.b2r = rise_sel;
        set_v.cmd = ev_cmd_done;
        set_v.dma = ev_dma_done;
        clr_v     = wr_status ? bits_to_evt(bus_wdata[NEVT-1:0]) : '0;
    end

    nrb_evt_regs u_regs (
        .clk(clk), .rst(rst), .srst(srst_q),
        .set(set_v), .clr(clr_v),
        .en_wr(wr_en), .en_wdata(bits_to_evt(bus_wdata[NEVT-1:0])),
        .flags(flags), .en(en)
    );

    assign irq = |(evt_to_bits(flags) & evt_to_bits(en));

    always_comb begin
        bus_rdata = '0;
        case (addr)
            RA_STATUS: begin
                bus_rdata[NEVT-1:0]       = evt_to_bits(flags);
                bus_rdata[LIVE_LSB +: N]  = lvl;
            end
            RA_IRQEN:  bus_rdata[NEVT-1:0] = evt_to_bits(en);
            RA_CTRL: begin
                bus_rdata[SRST_BIT]        = srst_q;
                bus_rdata[SEL_LSB +: SELW] = sel_q;
            end
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/nrb_irq_chk.sv
module nrb_irq_chk
    import nrb_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          bus_wr,
    input logic [1:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          ev_cmd_done,
    input logic          ev_dma_done,
    input logic          rise_sel,
    input evt_t          flags,
    input evt_t          en,
    input logic          srst_q,
    input logic          irq
);
    logic wr_st, wr_ct;
    assign wr_st = bus_wr && (bus_addr == 2'd0);
    assign wr_ct = bus_wr && (bus_addr == 2'd2);

    AST_W1C_ALL: assert property (@(posedge clk) disable iff (rst)
        (wr_st && bus_wdata[2:0] == 3'b111 && !ev_cmd_done && !ev_dma_done && !rise_sel)
        |=> (evt_to_bits(flags) == 3'b000)); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.b2r && !(wr_st && bus_wdata[0]) && !srst_q) |=> flags.b2r); // R6

    AST_CMD_SETS: assert property (@(posedge clk) disable iff (rst)
        (ev_cmd_done && !srst_q) |=> flags.cmd); // R5

    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (rst)
        (ev_dma_done && wr_st && bus_wdata[2] && !srst_q) |=> flags.dma); // R7

    AST_RISE_SETS: assert property (@(posedge clk) disable iff (rst)
        (rise_sel && !srst_q) |=> flags.b2r); // R3

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        (evt_to_bits(en) == 3'b000) |-> !irq); // R8

    AST_SRST_CLEARS: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> (evt_to_bits(flags) == 3'b000 && evt_to_bits(en) == 3'b000)); // R9

    AST_SRST_SELF_CLR: assert property (@(posedge clk) disable iff (rst)
        srst_q |=> !srst_q); // R9

    AST_SRST_START: assert property (@(posedge clk) disable iff (rst)
        (wr_ct && bus_wdata[1] && !srst_q) |=> srst_q); // R9
endmodule

bind nrb_irq_top nrb_irq_chk u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ev_cmd_done(ev_cmd_done), .ev_dma_done(ev_dma_done),
    .rise_sel(rise_sel), .flags(flags), .en(en), .srst_q(srst_q), .irq(irq)
);

// File: tb/sim_nrb_irq_top.sv
`timescale 1ns/1ps
module sim_nrb_irq_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  rb_line = 4'hF;
    logic        ev_cmd_done = 1'b0;
    logic        ev_dma_done = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    nrb_irq_top #(.N(4)) u0 (
        .clk(clk), .rst(rst), .rb_line(rb_line),
        .ev_cmd_done(ev_cmd_done), .ev_dma_done(ev_dma_done),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
        bus_addr = 2'd0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); chk("R1", "status after reset", d, 32'h0000_0F00);
        rd(2'd1, d); chk("R1", "enable after reset", d, 32'h0);
        rd(2'd2, d); chk("R1", "control after reset", d, 32'h0);
        chk("R1", "irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_live;
        logic [31:0] d;
        rb_line[2] = 1'b0;
        tick();
        rd(2'd0, d); chk("R2", "live bit10 after 1 edge", {31'b0, d[10]}, 32'h1);
        tick();
        rd(2'd0, d); chk("R2", "live levels after 2 edges", d, 32'h0000_0B00);
    endtask

    task automatic t_rise_selected;
        logic [31:0] d;
        rb_line[0] = 1'b0;
        tick(4);
        rd(2'd0, d); chk("R10", "fall leaves flag clear", d[2:0], 3'b000);
        rb_line[0] = 1'b1;
        tick(2);
        rd(2'd0, d); chk("R3", "flag not yet at 2 edges", d[2:0], 3'b000);
        tick();
        rd(2'd0, d); chk("R3", "flag after 3 edges", d[2:0], 3'b001);
        wr(2'd0, 32'h1);
        rd(2'd0, d); chk("R6", "b2r cleared by W1C", d[2:0], 3'b000);
    endtask

    task automatic t_select;
        logic [31:0] d;
        rb_line[2] = 1'b1;
        tick(4);
        rd(2'd0, d); chk("R3", "unselected rise ignored", d[2:0], 3'b000);
        wr(2'd2, 32'h10);
        rd(2'd2, d); chk("R4", "select readback", d, 32'h10);
        rb_line[2] = 1'b0;
        tick(4);
        rb_line[0] = 1'b0;
        rb_line[2] = 1'b1;
        tick(2);
        rd(2'd0, d); chk("R4", "sel2 flag not yet", d[2:0], 3'b000);
        tick();
        rd(2'd0, d); chk("R4", "sel2 rise sets flag", d[2:0], 3'b001);
        chk("R8", "irq low while disabled", {31'b0, irq}, 32'h0);
        rb_line[0] = 1'b1;
        tick(4);
        rd(2'd0, d); chk("R4", "line0 rise ignored with sel2", d[2:0], 3'b001);
        wr(2'd0, 32'h7);
    endtask

    task automatic t_events;
        logic [31:0] d;
        ev_cmd_done = 1'b1; tick(); ev_cmd_done = 1'b0;
        rd(2'd0, d); chk("R5", "cmd flag set", d[2:0], 3'b010);
        chk("R8", "irq low with enables 0", {31'b0, irq}, 32'h0);
        wr(2'd1, 32'h2);
        chk("R8", "irq high once enabled", {31'b0, irq}, 32'h1);
        ev_dma_done = 1'b1; tick(); ev_dma_done = 1'b0;
        rd(2'd0, d); chk("R5", "dma flag set", d[2:0], 3'b110);
        wr(2'd0, 32'h0);
        rd(2'd0, d); chk("R6", "write zero keeps flags", d[2:0], 3'b110);
        wr(2'd0, 32'h2);
        rd(2'd0, d); chk("R6", "cmd cleared, dma kept", d[2:0], 3'b100);
        chk("R8", "irq low after clear", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_collide;
        logic [31:0] d;
        ev_dma_done = 1'b1;
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 32'h4;
        tick();
        ev_dma_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rd(2'd0, d); chk("R7", "set wins over clear", d[2:0], 3'b100);
        wr(2'd0, 32'h4);
        rd(2'd0, d); chk("R6", "dma cleared", d[2:0], 3'b000);
    endtask

    task automatic t_srst;
        logic [31:0] d;
        wr(2'd1, 32'h7);
        ev_cmd_done = 1'b1; tick(); ev_cmd_done = 1'b0;
        chk("R8", "irq high before soft reset", {31'b0, irq}, 32'h1);
        wr(2'd2, 32'h0000_0012);
        rd(2'd2, d); chk("R9", "reset bit reads 1", d, 32'h12);
        tick();
        rd(2'd2, d); chk("R9", "reset bit self-clears, sel kept", d, 32'h10);
        rd(2'd0, d); chk("R9", "flags cleared", d[2:0], 3'b000);
        rd(2'd1, d); chk("R9", "enables cleared", d, 32'h0);
        chk("R9", "irq low after soft reset", {31'b0, irq}, 32'h0);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick();
        t_reset();
        t_live();
        t_rise_selected();
        t_select();
        t_events();
        t_collide();
        t_srst();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule